// File: doc/BRIEF.md
# Four-Bank Auto-Precharge Interrupt Tracker

This block follows the state of every bank inside a cycle-level SDRAM device model. It takes one already-registered command per clock. Each command carries a bank number, an auto-precharge flag, the CAS latency in force and the level of the data-mask input. From these it keeps each bank in one of five states. It also works out which bank, if any, drives or receives a data beat in each cycle.

A burst issued with auto-precharge does not have to run to its end. A READ or WRITE to a different bank cuts it short. The tracker decides two things for the cut bank: the cycle in which its data beats stop, and the cycle in which it starts to precharge. An uncut auto-precharge burst precharges its bank once its last beat has gone. Row timing other than the fixed precharge count is outside this block, and so is the storage array.

Timing convention: a command presented in cycle t is captured at the edge that ends cycle t. Every output that it changes first shows the change in cycle t+1.

Top module: `apc_bank_tracker`

## Requirements
- R1: After reset every bank reads 0 on `bank_state_o` and no flag or bus output is asserted. The state codes are 0 idle, 1 active, 2 reading, 3 writing and 4 precharging; bank k uses bits [3k+2:3k].
- R2: Command codes are 0 no-op, 1 activate, 2 read, 3 write and 4 precharge. An activate to an idle bank makes it active in t+1. A precharge to an active bank shows precharging for PRE_CYC cycles starting at t+1, and the bank is idle after that.
- R3: A read to an active bank makes it reading in t+1. Its BL beats occupy cycles t+CL through t+CL+BL-1, with `bus_busy_o`=1, `bus_bank_o`=bank and `bus_is_read_o`=1. CL is taken from `cas_i`, and the values 0 and 1 count as 2.
- R4: A write to an active bank makes it writing in t+1. Its BL beats occupy cycles t+1 through t+BL, with `bus_is_read_o`=0.
- R5: When a burst runs to its end without being cut, the bank changes state in the cycle after its last beat. With auto-precharge it becomes precharging (timed as in R2); without auto-precharge it becomes active.
- R6: A read to bank m in cycle t cuts a burst on another bank n. If n is reading, its last beat is at t+CL-1. If n is writing, it has no beat after t. If n had auto-precharge, it is precharging from t+1.
- R7: A write to bank m in cycle t cuts any burst on another bank n, so that n has no beat after t. If n had auto-precharge, it is precharging from t+1.
- R8: A bank whose burst was cut without auto-precharge stays in its burst state until its final remaining beat. It becomes active in the cycle after that beat, or in t+1 if no beat remains.
- R9: In any cycle at most one bank owns a data beat. When no bank owns one, `bus_busy_o`, `bus_bank_o` and `bus_is_read_o` are 0.
- R10: Some commands are illegal: an activate to a bank that is not idle, and a read, write or precharge to a bank that is not active. An illegal command raises `illegal_o` in t+1 and changes no bank. Codes 5 to 7 are no-ops and are not flagged.
- R11: A legal write in cycle t raises `dm_viol_o` in t+1 when two conditions hold: `dm_i` was low in cycle t-2, and another bank still has read beats due in cycle t or later. The write is carried out either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_i | input | 3 | command code (R2) |
| bank_i | input | $clog2(NB) | target bank |
| ap_i | input | 1 | auto-precharge flag for read or write |
| cas_i | input | 2 | CAS latency setting |
| dm_i | input | 1 | data-mask level this cycle |
| bank_state_o | output | 3*NB | per-bank state codes |
| bus_busy_o | output | 1 | a data beat is on the bus this cycle |
| bus_bank_o | output | $clog2(NB) | bank owning the beat |
| bus_is_read_o | output | 1 | beat is read data |
| illegal_o | output | 1 | previous command was rejected |
| dm_viol_o | output | 1 | previous write lacked the early data mask |

## Verification
The directed patterns cover five cases:
- a read cut by a read, at CAS latency 3: the trailing beat of the first read must still appear, and only one;
- a read cut by a write, both with and without the early mask: this separates immediate stopping from the CAS-delayed stop, and tests the mask-history check;
- an auto-precharge read left to finish;
- a precharge command;
- commands aimed at banks in the wrong state.

Random traffic then biases commands toward legal ones. Back-to-back reads with mixed latencies, and writes landing on pending reads, are compared every cycle against a bench model. This shows whether truncation ever lets two banks overlap, and whether pending bursts that are cut to zero beats still move their bank to the right state.

// File: rtl/apc_pkg.sv
package apc_pkg;

    typedef enum logic [2:0] {
        BK_IDLE = 3'd0,
        BK_OPEN = 3'd1,
        BK_RD   = 3'd2,
        BK_WR   = 3'd3,
        BK_PRE  = 3'd4
    } bank_st_e;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_ACT = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_WR  = 3'd3;
    localparam logic [2:0] OP_PRE = 3'd4;

    localparam int ST_W = 3;

    // latency values below 2 are raised to 2
    function automatic logic [1:0] eff_cl(input logic [1:0] raw);
        return (raw < 2'd2) ? 2'd2 : raw;
    endfunction

endpackage

// File: rtl/apc_cmd_check.sv
module apc_cmd_check
    import apc_pkg::*;
#(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cmd_i,
    input  logic [BW-1:0]   bank_i,
    input  logic            dm_i,
    input  bank_st_e        st_i [NB],
    input  logic [NB-1:0]   rdb_i,
    output logic [NB-1:0]   go_act_o,
    output logic [NB-1:0]   go_rd_o,
    output logic [NB-1:0]   go_wr_o,
    output logic [NB-1:0]   go_pre_o,
    output logic            illegal_o,
    output logic            dm_viol_o
);

    logic     is_act, is_rd, is_wr, is_pre, ok;
    bank_st_e sel_st;
    logic     dm_h1, dm_h2;
    logic     ill_n, dmv_n;

    always_comb begin
        is_act = (cmd_i == OP_ACT);
        is_rd  = (cmd_i == OP_RD);
        is_wr  = (cmd_i == OP_WR);
        is_pre = (cmd_i == OP_PRE);
        sel_st = st_i[bank_i];
        ok     = (is_act && sel_st == BK_IDLE) ||
                 ((is_rd || is_wr || is_pre) && sel_st == BK_OPEN);
        ill_n  = (is_act || is_rd || is_wr || is_pre) && !ok;
        dmv_n  = is_wr && ok && (|rdb_i) && !dm_h2;
    end

    for (genvar k = 0; k < NB; k++) begin : g_go
        assign go_act_o[k] = ok && is_act && (bank_i == BW'(k));
        assign go_rd_o[k]  = ok && is_rd  && (bank_i == BW'(k));
        assign go_wr_o[k]  = ok && is_wr  && (bank_i == BW'(k));
        assign go_pre_o[k] = ok && is_pre && (bank_i == BW'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dm_h1     <= 1'b0;
            dm_h2     <= 1'b0;
            illegal_o <= 1'b0;
            dm_viol_o <= 1'b0;
        end else begin
            dm_h1     <= dm_i;
            dm_h2     <= dm_h1;
            illegal_o <= ill_n;
            dm_viol_o <= dmv_n;
        end
    end

    // R10: a flagged command released no bank action in its cycle
    p_illegal_inert_r10: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past((go_act_o | go_rd_o | go_wr_o | go_pre_o) == '0));

endmodule

// File: rtl/apc_bank_unit.sv
module apc_bank_unit
    import apc_pkg::*;
#(
    parameter int BL      = 4,
    parameter int PRE_CYC = 3,
    localparam int CW     = $clog2(BL + 4) + 1,
    localparam int PW     = $clog2(PRE_CYC) + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go_act,
    input  logic     go_rd,
    input  logic     go_wr,
    input  logic     go_pre,
    input  logic     ap_i,
    input  logic [1:0] cl_i,
    input  logic     oth_rd,
    input  logic     oth_wr,
    output bank_st_e st_o,
    output logic     beat_o,
    output logic     kind_o,
    output logic     rdb_o
);

    bank_st_e        st_q, st_n;
    logic [CW-1:0]   s_q, e_q, s_n, e_n, s_dec, e_dec, cut, clx;
    logic [PW-1:0]   p_q, p_n;
    logic            ap_q, ap_n, rd_q, rd_n, oth;

    always_comb begin
        clx   = {{(CW-2){1'b0}}, cl_i};
        oth   = oth_rd || oth_wr;
        s_dec = (s_q != '0) ? s_q - 1'b1 : '0;
        e_dec = (e_q != '0) ? e_q - 1'b1 : '0;
        // a read on another bank lets a read finish up to its own first beat
        cut   = (oth_rd && rd_q) ? clx - 1'b1 : '0;

        if (go_rd) begin
            s_n = clx - 1'b1;
            e_n = clx - 1'b1 + CW'(BL);
        end else if (go_wr) begin
            s_n = '0;
            e_n = CW'(BL);
        end else begin
            s_n = s_dec;
            e_n = (oth && e_dec > cut) ? cut : e_dec;
        end

        st_n = st_q;
        ap_n = ap_q;
        rd_n = rd_q;
        p_n  = p_q;
        case (st_q)
            BK_IDLE: if (go_act) st_n = BK_OPEN;
            BK_OPEN: begin
                if (go_rd) begin
                    st_n = BK_RD;
                    ap_n = ap_i;
                    rd_n = 1'b1;
                end else if (go_wr) begin
                    st_n = BK_WR;
                    ap_n = ap_i;
                    rd_n = 1'b0;
                end else if (go_pre) begin
                    st_n = BK_PRE;
                    p_n  = PW'(PRE_CYC - 1);
                end
            end
            BK_RD, BK_WR: begin
                if ((oth && ap_q) || e_n == '0) begin
                    st_n = ap_q ? BK_PRE : BK_OPEN;
                    p_n  = PW'(PRE_CYC - 1);
                end
            end
            BK_PRE: begin
                if (p_q == '0) st_n = BK_IDLE;
                else           p_n  = p_q - 1'b1;
            end
            default: st_n = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= BK_IDLE;
            s_q  <= '0;
            e_q  <= '0;
            p_q  <= '0;
            ap_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            st_q <= st_n;
            s_q  <= s_n;
            e_q  <= e_n;
            p_q  <= p_n;
            ap_q <= ap_n;
            rd_q <= rd_n;
        end
    end

    assign st_o   = st_q;
    assign beat_o = (s_q == '0) && (e_q != '0);
    assign kind_o = rd_q;
    assign rdb_o  = rd_q && (e_q != '0);

    // R2: activation only ever reaches an idle bank
    p_act_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        go_act |-> st_q == BK_IDLE);

    // R8: an open bank has no beat left in flight
    p_open_no_beat_r8: assert property (@(posedge clk) disable iff (rst)
        beat_o |-> st_q != BK_OPEN);

    // R7: a cut auto-precharge burst precharges in the next cycle
    p_cut_precharge_r7: assert property (@(posedge clk) disable iff (rst)
        ((oth_rd || oth_wr) && ap_q && (st_q == BK_RD || st_q == BK_WR))
        |=> st_q == BK_PRE);

endmodule

// File: rtl/apc_bus_owner.sv
module apc_bus_owner #(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic [NB-1:0] beat_i,
    input  logic [NB-1:0] kind_i,
    output logic          busy_o,
    output logic [BW-1:0] bank_o,
    output logic          is_read_o
);

    always_comb begin
        busy_o    = 1'b0;
        bank_o    = '0;
        is_read_o = 1'b0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (beat_i[k]) begin
                busy_o    = 1'b1;
                bank_o    = BW'(k);
                is_read_o = kind_i[k];
            end
        end
    end

endmodule

// File: rtl/apc_bank_tracker.sv
module apc_bank_tracker
    import apc_pkg::*;
#(
    parameter int NB      = 4,
    parameter int BL      = 4,
    parameter int PRE_CYC = 3,
    localparam int BW     = $clog2(NB)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         cmd_i,
    input  logic [BW-1:0]      bank_i,
    input  logic               ap_i,
    input  logic [1:0]         cas_i,
    input  logic               dm_i,
    output logic [ST_W*NB-1:0] bank_state_o,
    output logic               bus_busy_o,
    output logic [BW-1:0]      bus_bank_o,
    output logic               bus_is_read_o,
    output logic               illegal_o,
    output logic               dm_viol_o
);

    bank_st_e      st [NB];
    logic [NB-1:0] go_act, go_rd, go_wr, go_pre;
    logic [NB-1:0] beat, kind, rdb;
    logic [1:0]    cl_eff;

    assign cl_eff = eff_cl(cas_i);

    apc_cmd_check #(.NB(NB)) u_check (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd_i),
        .bank_i    (bank_i),
        .dm_i      (dm_i),
        .st_i      (st),
        .rdb_i     (rdb),
        .go_act_o  (go_act),
        .go_rd_o   (go_rd),
        .go_wr_o   (go_wr),
        .go_pre_o  (go_pre),
        .illegal_o (illegal_o),
        .dm_viol_o (dm_viol_o)
    );

    for (genvar k = 0; k < NB; k++) begin : g_bank
        logic [NB-1:0] others;
        assign others = ~(NB'(1) << k);

        apc_bank_unit #(.BL(BL), .PRE_CYC(PRE_CYC)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .go_act (go_act[k]),
            .go_rd  (go_rd[k]),
            .go_wr  (go_wr[k]),
            .go_pre (go_pre[k]),
            .ap_i   (ap_i),
            .cl_i   (cl_eff),
            .oth_rd (|(go_rd & others)),
            .oth_wr (|(go_wr & others)),
            .st_o   (st[k]),
            .beat_o (beat[k]),
            .kind_o (kind[k]),
            .rdb_o  (rdb[k])
        );

        assign bank_state_o[k*ST_W +: ST_W] = st[k];
    end

    apc_bus_owner #(.NB(NB)) u_owner (
        .beat_i    (beat),
        .kind_i    (kind),
        .busy_o    (bus_busy_o),
        .bank_o    (bus_bank_o),
        .is_read_o (bus_is_read_o)
    );

    // R9: truncation never lets two banks share a beat
    p_single_owner_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(beat));

    // R4: an accepted write owns the bus in the following cycle
    p_write_drives_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (|go_wr) |=> (bus_busy_o && !bus_is_read_o));

endmodule

// File: tb/apc_bank_tracker_bench.sv
module apc_bank_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int BL = 4;
    localparam int PC = 3;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd_i;
    logic [1:0]  bank_i;
    logic        ap_i;
    logic [1:0]  cas_i;
    logic        dm_i;
    logic [11:0] bank_state_o;
    logic        bus_busy_o;
    logic [1:0]  bus_bank_o;
    logic        bus_is_read_o;
    logic        illegal_o;
    logic        dm_viol_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    apc_bank_tracker #(.NB(NB), .BL(BL), .PRE_CYC(PC)) u_apc_bank_tracker (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
        .cas_i(cas_i), .dm_i(dm_i), .bank_state_o(bank_state_o),
        .bus_busy_o(bus_busy_o), .bus_bank_o(bus_bank_o),
        .bus_is_read_o(bus_is_read_o), .illegal_o(illegal_o),
        .dm_viol_o(dm_viol_o)
    );

    // bench model of the requirements
    int m_st [NB];
    int m_s  [NB];
    int m_e  [NB];
    int m_p  [NB];
    bit m_ap [NB];
    bit m_rd [NB];
    bit m_ill, m_dmv, m_h1, m_h2;

    task automatic model_reset();
        for (int k = 0; k < NB; k++) begin
            m_st[k] = 0; m_s[k] = 0; m_e[k] = 0; m_p[k] = 0;
            m_ap[k] = 0; m_rd[k] = 0;
        end
        m_ill = 0; m_dmv = 0; m_h1 = 0; m_h2 = 0;
    endtask

    task automatic model_step(int c, int b, bit ap, int cas, bit dm);
        int  cl;
        bit  ok, anyrd;
        int  ns [NB];
        int  ne [NB];
        int  nst [NB];
        int  np [NB];
        bit  nap [NB];
        bit  nrd [NB];
        cl = (cas < 2) ? 2 : cas;
        ok = (c == 1 && m_st[b] == 0) || (c >= 2 && c <= 4 && m_st[b] == 1);
        anyrd = 0;
        for (int k = 0; k < NB; k++) if (m_rd[k] && m_e[k] > 0) anyrd = 1;
        for (int k = 0; k < NB; k++) begin
            bit own, oth;
            int cut;
            own = ok && (k == b);
            oth = ok && (c == 2 || c == 3) && (k != b);
            cut = (oth && c == 2 && m_rd[k]) ? cl - 1 : 0;
            ns[k] = (m_s[k] > 0) ? m_s[k] - 1 : 0;
            ne[k] = (m_e[k] > 0) ? m_e[k] - 1 : 0;
            if (oth && ne[k] > cut) ne[k] = cut;
            nst[k] = m_st[k]; np[k] = m_p[k]; nap[k] = m_ap[k]; nrd[k] = m_rd[k];
            if (own) begin
                case (c)
                    1: nst[k] = 1;
                    2: begin nst[k] = 2; ns[k] = cl - 1; ne[k] = cl - 1 + BL; nap[k] = ap; nrd[k] = 1; end
                    3: begin nst[k] = 3; ns[k] = 0; ne[k] = BL; nap[k] = ap; nrd[k] = 0; end
                    default: begin nst[k] = 4; np[k] = PC - 1; end
                endcase
            end else if (m_st[k] == 2 || m_st[k] == 3) begin
                if ((oth && m_ap[k]) || ne[k] == 0) begin
                    nst[k] = m_ap[k] ? 4 : 1;
                    np[k] = PC - 1;
                end
            end else if (m_st[k] == 4) begin
                if (m_p[k] == 0) nst[k] = 0;
                else np[k] = m_p[k] - 1;
            end
        end
        m_ill = (c >= 1 && c <= 4) && !ok;
        m_dmv = ok && c == 3 && anyrd && !m_h2;
        m_h2 = m_h1;
        m_h1 = dm;
        for (int k = 0; k < NB; k++) begin
            m_st[k] = nst[k]; m_s[k] = ns[k]; m_e[k] = ne[k]; m_p[k] = np[k];
            m_ap[k] = nap[k]; m_rd[k] = nrd[k];
        end
    endtask

    function automatic int exp_states();
        int v = 0;
        for (int k = 0; k < NB; k++) v = v | (m_st[k] << (3*k));
        return v;
    endfunction

    // packed {busy, bank, is_read}
    function automatic int exp_bus();
        for (int k = 0; k < NB; k++)
            if (m_s[k] == 0 && m_e[k] > 0) return 8 | (k << 1) | int'(m_rd[k]);
        return 0;
    endfunction

    function automatic int dut_bus();
        return (int'(bus_busy_o) << 3) | (int'(bus_bank_o) << 1) | int'(bus_is_read_o);
    endfunction

    function automatic int dut_st(int k);
        return int'(bank_state_o[3*k +: 3]);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R5", "bank states", int'(bank_state_o), exp_states());
        check("R9", "bus owner", dut_bus(), exp_bus());
        check("R10", "illegal flag", int'(illegal_o), int'(m_ill));
        check("R11", "mask flag", int'(dm_viol_o), int'(m_dmv));
    endtask

    task automatic tick(int c, int b, bit ap, int cas, bit dm);
        compare_all();
        cmd_i = 3'(c); bank_i = 2'(b); ap_i = ap; cas_i = 2'(cas); dm_i = dm;
        model_step(c, b, ap, cas, dm);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 2, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; cmd_i = 0; bank_i = 0; ap_i = 0; cas_i = 2; dm_i = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", "states after reset", int'(bank_state_o), 0);
        check("R1", "bus after reset", dut_bus(), 0);
        check("R1", "flags after reset", int'({illegal_o, dm_viol_o}), 0);

        // R2 activate, then precharge timing
        tick(1, 0, 0, 2, 0);
        check("R2", "bank0 active", dut_st(0), 1);
        tick(4, 0, 0, 2, 0);
        check("R2", "bank0 precharging t+1", dut_st(0), 4);
        idle(2);
        check("R2", "bank0 precharging t+3", dut_st(0), 4);
        idle(1);
        check("R2", "bank0 idle t+4", dut_st(0), 0);

        // R3 / R5: auto-precharge read runs out, CL=2
        tick(1, 2, 0, 2, 0);
        tick(2, 2, 1, 2, 0);
        check("R3", "bank2 reading", dut_st(2), 2);
        check("R3", "no beat at t+1", int'(bus_busy_o), 0);
        idle(1);
        check("R3", "first read beat t+2", dut_bus(), 8 | (2 << 1) | 1);
        idle(3);
        check("R3", "last read beat t+5", dut_bus(), 8 | (2 << 1) | 1);
        idle(1);
        check("R5", "bank2 precharging after last beat", dut_st(2), 4);
        check("R5", "bus free after burst", int'(bus_busy_o), 0);
        idle(4);

        // R6: read on bank1 cuts auto-precharge read on bank0, CL=3
        tick(1, 0, 0, 3, 0);
        tick(1, 1, 0, 3, 0);
        tick(2, 0, 1, 3, 0);
        tick(2, 1, 0, 3, 0);
        check("R6", "bank0 precharging at t+2", dut_st(0), 4);
        idle(1);
        check("R6", "bank0 trailing beat t+3", dut_bus(), 8 | 1);
        idle(1);
        check("R6", "bank1 owns t+4", dut_bus(), 8 | (1 << 1) | 1);
        idle(4);
        check("R5", "bank1 active after plain read", dut_st(1), 1);
        idle(4);

        // R7 / R11: write on bank0 cuts auto-precharge read on bank1, no early mask
        tick(1, 0, 0, 2, 0);
        tick(2, 1, 1, 2, 0);
        tick(0, 0, 0, 2, 0);
        tick(3, 0, 0, 2, 0);
        check("R11", "mask violation flagged", int'(dm_viol_o), 1);
        check("R7", "bank1 precharging", dut_st(1), 4);
        check("R7", "bank0 write owns bus", dut_bus(), 8);
        idle(6);

        // R11 / R8: with early mask, plain read on bank1 cut by write
        tick(1, 1, 0, 2, 0);
        tick(2, 1, 0, 2, 1);
        tick(0, 0, 0, 2, 0);
        tick(3, 0, 0, 2, 0);
        check("R11", "no violation with early mask", int'(dm_viol_o), 0);
        check("R8", "bank1 back to active", dut_st(1), 1);
        check("R7", "write beat not read", dut_bus(), 8);
        idle(6);

        // R10: illegal commands
        tick(1, 0, 0, 2, 0);
        check("R10", "activate to open bank flagged", int'(illegal_o), 1);
        check("R10", "bank0 unchanged", dut_st(0), 1);
        tick(6, 0, 0, 2, 0);
        check("R10", "code 6 not flagged", int'(illegal_o), 0);
        tick(2, 3, 0, 2, 0);
        check("R10", "read to idle bank flagged", int'(illegal_o), 1);
        check("R10", "bank3 still idle", dut_st(3), 0);

        // R3: latency value 0 counts as 2
        tick(1, 3, 0, 2, 0);
        tick(2, 3, 0, 0, 0);
        check("R3", "clamped CL no beat t+1", int'(bus_busy_o), 0);
        idle(1);
        check("R3", "clamped CL beat t+2", dut_bus(), 8 | (3 << 1) | 1);
        idle(8);

        // random traffic biased toward legal commands
        for (int i = 0; i < 4000; i++) begin
            int b, c, r;
            b = int'($urandom % NB);
            r = int'($urandom % 16);
            if (r < 2)       c = int'($urandom % 8);
            else if (r < 4)  c = 0;
            else if (m_st[b] == 0) c = 1;
            else if (m_st[b] == 1) c = (r < 8) ? 2 : (r < 13) ? 3 : 4;
            else c = int'($urandom % 5);
            tick(c, b, 1'($urandom), int'($urandom % 4), 1'($urandom));
        end
        compare_all();
        finish_run();
    end

endmodule